// File: doc/BRIEF.md
# Capability-Gated CSR Access Checker

This unit sits beside the CSR decode stage of a RISC-V core that carries capabilities in its registers. It decides in the same cycle whether a decoded CSR access may go ahead. It also decides whether a capability-specific instruction must trap as illegal. Two things drive the decision: a system-register-access permission bit carried by the program-counter capability, and the privilege mode of the hart.

Without that permission, only a short list of CSRs is open. These are the counters (read only) and the floating-point status CSRs (read and write). The three per-mode capability control registers always need the permission and a high enough privilege mode. The unit stores those three registers. Their two top bits are read-only flags that reset to 1, and every other bit stays 0.

Capability instructions are switched on or off for each mode by the enable bits of the machine and supervisor environment-configuration CSRs. Both enables come from bit 28 of their CSR.

Top module: `cap_csr_gate`

## Requirements
- R1: At reset, every capability control register (user 0x8C0, supervisor 0x9C0, machine 0xBC0) reads as bit 31 = 1, bit 30 = 1 and all other bits 0 (0xC000_0000 for XLEN = 32). This value is visible on an allowed read even while reset is held.
- R2: Without the access permission, a read-only access to 0xC00–0xC1F or 0xC80–0xC9F is allowed. Any other address outside the floating-point status CSRs is refused.
- R3: Without the access permission, 0x001, 0x002 and 0x003 are allowed for read, for write, and for both together.
- R4: Without the access permission, any write to a counter address (0xC00–0xC1F, 0xC80–0xC9F) is refused.
- R5: Without the access permission, all three capability control registers are refused in every mode.
- R6: With the access permission, 0x8C0 is allowed in any mode, 0x9C0 only in S or M mode, and 0xBC0 only in M mode. The privilege encoding is 00 = U, 01 = S, 11 = M, and 10 is treated as U.
- R7: With the access permission, any CSR address other than 0x9C0 and 0xBC0 is allowed in any mode.
- R8: A capability instruction raises illegal-instruction when it is not enabled. It is always enabled in M mode. In S mode it needs the machine enable. In U mode it needs both the machine and the supervisor enables.
- R9: When the capability-instruction flag is low and no CSR access is requested, the unit raises no illegal-instruction request and asserts no allow, whatever the enable bits are. Legacy loads and stores through the default data capability therefore pass.
- R10: Writes to the capability control registers leave every bit unchanged: the flags are read-only and the remaining bits keep their reset value.
- R11: The read-data output is zero unless the cycle carries an allowed read of a capability control register.
- R12: A requested CSR access that is not allowed raises the illegal-instruction request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_addr_i | input | 12 | CSR address of the decoded access |
| csr_rd_i | input | 1 | Access reads the CSR |
| csr_wr_i | input | 1 | Access writes the CSR |
| csr_wdata_i | input | XLEN | Write data for the capability control registers |
| priv_i | input | 2 | Current privilege mode |
| pcc_asr_i | input | 1 | System-register-access permission of the program-counter capability |
| menv_cap_en_i | input | 1 | Capability enable from the machine environment-configuration CSR (bit 28) |
| senv_cap_en_i | input | 1 | Capability enable from the supervisor environment-configuration CSR (bit 28) |
| cap_insn_i | input | 1 | Decoded instruction is capability-specific |
| csr_allow_o | output | 1 | The requested CSR access may proceed |
| illegal_insn_o | output | 1 | Raise an illegal-instruction fault |
| ccsr_rdata_o | output | XLEN | Read data of the capability control registers |

## Verification
The assertions check the following on every cycle: counter writes without the permission are refused, and the control registers are closed without the permission. They also check that the machine register is refused below M mode, and that every refusal raises illegal. M-mode capability instructions never trap, control-register reads return the reset pattern, and read data is zero outside allowed reads.

The bench scenarios cover what a single-cycle property cannot show. These are the exact edges of the whitelist ranges, the per-mode enable table with the enables in each combination, the reset value while reset is held, and the readback after an all-ones write.

// File: rtl/cap_csr_pkg.sv
package cap_csr_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_R = 2'b10,
    PRIV_M = 2'b11
  } priv_e;

  localparam int unsigned CSR_AW    = 12;
  localparam int unsigned NUM_CCSR  = 3;

  // index 0 user, 1 supervisor, 2 machine
  function automatic logic [CSR_AW-1:0] ccsr_addr(input int unsigned idx);
    case (idx)
      0:       return 12'h8C0;
      1:       return 12'h9C0;
      default: return 12'hBC0;
    endcase
  endfunction

  function automatic logic ccsr_priv_ok(input int unsigned idx, input priv_e p);
    case (idx)
      0:       return 1'b1;
      1:       return (p == PRIV_S) || (p == PRIV_M);
      default: return (p == PRIV_M);
    endcase
  endfunction
endpackage

// File: rtl/cap_csr_whitelist.sv
module cap_csr_whitelist #(
  parameter int unsigned       AW        = 12,
  parameter int unsigned       FP_LO     = 1,
  parameter int unsigned       FP_HI     = 3,
  parameter logic [AW-1:0]     CNT_BASE  = 12'hC00,
  parameter logic [AW-1:0]     CNTH_BASE = 12'hC80,
  parameter int unsigned       CNT_SPAN  = 32
) (
  input  logic [AW-1:0] addr_i,
  output logic          rd_ok_o,
  output logic          wr_ok_o
);
  localparam int unsigned CB = $clog2(CNT_SPAN);

  logic fp_hit, cnt_hit, cnth_hit;

  assign fp_hit   = (addr_i >= AW'(FP_LO)) && (addr_i <= AW'(FP_HI));
  assign cnt_hit  = addr_i[AW-1:CB] == CNT_BASE[AW-1:CB];
  assign cnth_hit = addr_i[AW-1:CB] == CNTH_BASE[AW-1:CB];

  assign rd_ok_o = fp_hit | cnt_hit | cnth_hit;
  assign wr_ok_o = fp_hit;
endmodule

// File: rtl/cap_csr_enable.sv
module cap_csr_enable
  import cap_csr_pkg::*;
(
  input  priv_e priv_i,
  input  logic  menv_en_i,
  input  logic  senv_en_i,
  output logic  cap_en_o
);
  always_comb begin
    case (priv_i)
      PRIV_M:  cap_en_o = 1'b1;
      PRIV_S:  cap_en_o = menv_en_i;
      default: cap_en_o = menv_en_i & senv_en_i;
    endcase
  end
endmodule

// File: rtl/cap_csr_ccsr_bank.sv
module cap_csr_ccsr_bank #(
  parameter int unsigned    XLEN    = 32,
  parameter int unsigned    NUM     = 3,
  parameter logic [XLEN-1:0] WR_MASK = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NUM-1:0]  wr_sel_i,
  input  logic [NUM-1:0]  rd_sel_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  // tag-clearing flag at XLEN-1, no-relocation flag at XLEN-2
  localparam logic [XLEN-1:0] RESET_VAL = {2'b11, {(XLEN-2){1'b0}}};

  logic [NUM-1:0][XLEN-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM; i++) regs_q[i] <= RESET_VAL;
    end else begin
      for (int i = 0; i < NUM; i++)
        if (wr_sel_i[i]) regs_q[i] <= (regs_q[i] & ~WR_MASK) | (wdata_i & WR_MASK);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM; i++)
      if (rd_sel_i[i]) rdata_o = rdata_o | regs_q[i];
  end
endmodule

// File: rtl/cap_csr_gate.sv
module cap_csr_gate
  import cap_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [11:0]     csr_addr_i,
  input  logic            csr_rd_i,
  input  logic            csr_wr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic [1:0]      priv_i,
  input  logic            pcc_asr_i,
  input  logic            menv_cap_en_i,
  input  logic            senv_cap_en_i,
  input  logic            cap_insn_i,
  output logic            csr_allow_o,
  output logic            illegal_insn_o,
  output logic [XLEN-1:0] ccsr_rdata_o
);
  priv_e                priv;
  logic [NUM_CCSR-1:0]  hit, mode_ok;
  logic                 wl_rd, wl_wr, cap_en, req;
  logic                 any_ccsr, asr_path_ok, plain_ok, allow;

  assign priv = priv_e'(priv_i);
  assign req  = csr_rd_i | csr_wr_i;

  for (genvar g = 0; g < NUM_CCSR; g++) begin : g_hit
    assign hit[g]     = csr_addr_i == ccsr_addr(g);
    assign mode_ok[g] = ccsr_priv_ok(g, priv);
  end

  cap_csr_whitelist #(.AW(CSR_AW)) u_wl (
    .addr_i  (csr_addr_i),
    .rd_ok_o (wl_rd),
    .wr_ok_o (wl_wr)
  );

  cap_csr_enable u_en (
    .priv_i    (priv),
    .menv_en_i (menv_cap_en_i),
    .senv_en_i (senv_cap_en_i),
    .cap_en_o  (cap_en)
  );

  assign any_ccsr    = |hit;
  assign asr_path_ok = any_ccsr ? |(hit & mode_ok) : 1'b1;
  assign plain_ok    = csr_wr_i ? wl_wr : wl_rd;
  assign allow       = req & (pcc_asr_i ? asr_path_ok : plain_ok);

  cap_csr_ccsr_bank #(.XLEN(XLEN), .NUM(NUM_CCSR)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (hit & {NUM_CCSR{csr_wr_i & allow}}),
    .rd_sel_i (hit & {NUM_CCSR{csr_rd_i & allow}}),
    .wdata_i  (csr_wdata_i),
    .rdata_o  (ccsr_rdata_o)
  );

  assign csr_allow_o    = allow;
  assign illegal_insn_o = (req & ~allow) | (cap_insn_i & ~cap_en);
endmodule

// File: rtl/cap_csr_gate_chk.sv
module cap_csr_gate_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [11:0]     csr_addr_i,
  input logic            csr_rd_i,
  input logic            csr_wr_i,
  input logic [1:0]      priv_i,
  input logic            pcc_asr_i,
  input logic            cap_insn_i,
  input logic            csr_allow_o,
  input logic            illegal_insn_o,
  input logic [XLEN-1:0] ccsr_rdata_o
);
  localparam logic [XLEN-1:0] FLAGS = {2'b11, {(XLEN-2){1'b0}}};

  logic is_ccsr;
  assign is_ccsr = (csr_addr_i == 12'h8C0) || (csr_addr_i == 12'h9C0) ||
                   (csr_addr_i == 12'hBC0);

  assert_cnt_nowrite_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr_i && !pcc_asr_i && csr_addr_i[11:8] == 4'hC) |-> !csr_allow_o);

  assert_ccsr_needs_asr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pcc_asr_i && is_ccsr) |-> !csr_allow_o);

  assert_mccsr_mmode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == 12'hBC0 && priv_i != 2'b11) |-> !csr_allow_o);

  assert_mmode_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == 2'b11 && cap_insn_i && !csr_rd_i && !csr_wr_i) |-> !illegal_insn_o);

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_rd_i && !csr_wr_i && !cap_insn_i) |-> (!illegal_insn_o && !csr_allow_o));

  assert_ccsr_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rd_i && csr_allow_o && is_ccsr) |-> ccsr_rdata_o == FLAGS);

  assert_rdata_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_rd_i && csr_allow_o && is_ccsr) |-> ccsr_rdata_o == '0);

  assert_refuse_traps_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((csr_rd_i || csr_wr_i) && !csr_allow_o) |-> illegal_insn_o);
endmodule

bind cap_csr_gate cap_csr_gate_chk #(.XLEN(XLEN)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .csr_addr_i     (csr_addr_i),
  .csr_rd_i       (csr_rd_i),
  .csr_wr_i       (csr_wr_i),
  .priv_i         (priv_i),
  .pcc_asr_i      (pcc_asr_i),
  .cap_insn_i     (cap_insn_i),
  .csr_allow_o    (csr_allow_o),
  .illegal_insn_o (illegal_insn_o),
  .ccsr_rdata_o   (ccsr_rdata_o)
);

// File: tb/sim_cap_csr_gate.sv
module sim_cap_csr_gate;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  typedef struct {
    logic        allow;
    logic        ill;
    logic [31:0] rdata;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic rd = 0, wr = 0, asr = 0, men = 0, sen = 0, capi = 0;
  logic [1:0] priv = 2'b11;
  logic [31:0] wdata = '0;
  logic allow, ill;
  logic [31:0] rdata;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t q[$];
  event mon_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_csr_gate #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_rd_i(rd), .csr_wr_i(wr),
    .csr_wdata_i(wdata), .priv_i(priv), .pcc_asr_i(asr), .menv_cap_en_i(men),
    .senv_cap_en_i(sen), .cap_insn_i(capi), .csr_allow_o(allow),
    .illegal_insn_o(ill), .ccsr_rdata_o(rdata)
  );

  function automatic exp_t model(input logic [11:0] a, input logic r, input logic w,
                                 input logic [1:0] p, input logic s, input logic me,
                                 input logic se, input logic ci, input string tag);
    exp_t e;
    logic req, wlr, wlw, ccsr, mok, en;
    req  = r | w;
    wlw  = (a >= 12'h001) && (a <= 12'h003);
    wlr  = wlw || (a >= 12'hC00 && a <= 12'hC1F) || (a >= 12'hC80 && a <= 12'hC9F);
    ccsr = (a == 12'h8C0) || (a == 12'h9C0) || (a == 12'hBC0);
    if (a == 12'h9C0)      mok = (p == 2'b01) || (p == 2'b11);
    else if (a == 12'hBC0) mok = (p == 2'b11);
    else                   mok = 1'b1;
    if (p == 2'b11)      en = 1'b1;
    else if (p == 2'b01) en = me;
    else                 en = me & se;
    e.allow = req && (s ? mok : (w ? wlw : wlr));
    e.ill   = (req && !e.allow) || (ci && !en);
    e.rdata = (r && e.allow && ccsr) ? 32'hC000_0000 : 32'h0;
    e.tag   = tag;
    return e;
  endfunction

  task automatic drive(input logic [11:0] a, input logic r, input logic w,
                       input logic [1:0] p, input logic s, input logic me,
                       input logic se, input logic ci, input logic [31:0] wd,
                       input string tag);
    @(negedge clk);
    addr = a; rd = r; wr = w; priv = p; asr = s; men = me; sen = se; capi = ci; wdata = wd;
    q.push_back(model(a, r, w, p, s, me, se, ci, tag));
    #1;
    -> mon_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(mon_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (allow !== e.allow || ill !== e.ill || rdata !== e.rdata) begin
          fails++;
          $display("FAIL %s: allow/illegal/rdata got %b/%b/%h expected %b/%b/%h",
                   e.tag, allow, ill, rdata, e.allow, e.ill, e.rdata);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset value visible while reset held
    drive(12'hBC0, 1, 0, 2'b11, 1, 0, 0, 0, 0, "R1 mccsr during reset");
    @(negedge clk); rst_n = 1'b1;
    drive(12'h8C0, 1, 0, 2'b11, 1, 0, 0, 0, 0, "R1 uccsr after reset");
    drive(12'h9C0, 1, 0, 2'b01, 1, 0, 0, 0, 0, "R1 sccsr after reset");
    // R2 counters readable without permission
    drive(12'hC00, 1, 0, 2'b00, 0, 1, 1, 0, 0, "R2 cycle read");
    drive(12'hC1F, 1, 0, 2'b00, 0, 1, 1, 0, 0, "R2 top counter");
    drive(12'hC85, 1, 0, 2'b01, 0, 1, 1, 0, 0, "R2 high half");
    drive(12'hC9F, 1, 0, 2'b11, 0, 1, 1, 0, 0, "R2 top high half");
    drive(12'hC20, 1, 0, 2'b11, 0, 1, 1, 0, 0, "R2 above counters");
    drive(12'hCA0, 1, 0, 2'b11, 0, 1, 1, 0, 0, "R2 above high halves");
    drive(12'h300, 1, 0, 2'b11, 0, 1, 1, 0, 0, "R2 mstatus refused");
    // R3 floating-point status
    drive(12'h001, 1, 1, 2'b00, 0, 1, 1, 0, 0, "R3 fflags rw");
    drive(12'h002, 0, 1, 2'b00, 0, 1, 1, 0, 0, "R3 frm write");
    drive(12'h003, 1, 0, 2'b00, 0, 1, 1, 0, 0, "R3 fcsr read");
    drive(12'h004, 1, 0, 2'b00, 0, 1, 1, 0, 0, "R3 beyond fcsr");
    // R4 counter writes refused
    drive(12'hC02, 0, 1, 2'b11, 0, 1, 1, 0, 0, "R4 instret write");
    drive(12'hC81, 1, 1, 2'b11, 0, 1, 1, 0, 0, "R4 timeh rw");
    // R5 control registers need permission
    drive(12'hBC0, 1, 0, 2'b11, 0, 1, 1, 0, 0, "R5 mccsr no perm");
    drive(12'h8C0, 1, 0, 2'b00, 0, 1, 1, 0, 0, "R5 uccsr no perm");
    // R6 mode gating
    drive(12'h8C0, 1, 0, 2'b00, 1, 1, 1, 0, 0, "R6 uccsr U");
    drive(12'h9C0, 1, 0, 2'b00, 1, 1, 1, 0, 0, "R6 sccsr U");
    drive(12'h9C0, 1, 0, 2'b10, 1, 1, 1, 0, 0, "R6 sccsr reserved priv");
    drive(12'hBC0, 1, 0, 2'b01, 1, 1, 1, 0, 0, "R6 mccsr S");
    drive(12'hBC0, 1, 0, 2'b11, 1, 1, 1, 0, 0, "R6 mccsr M");
    // R7 other CSRs with permission
    drive(12'h300, 1, 1, 2'b00, 1, 1, 1, 0, 0, "R7 mstatus with perm");
    drive(12'hC02, 0, 1, 2'b01, 1, 1, 1, 0, 0, "R7 counter write with perm");
    // R8 capability instruction enables
    drive(12'h000, 0, 0, 2'b00, 0, 1, 0, 1, 0, "R8 U senv clear");
    drive(12'h000, 0, 0, 2'b00, 0, 1, 1, 1, 0, "R8 U both set");
    drive(12'h000, 0, 0, 2'b01, 0, 0, 1, 1, 0, "R8 S menv clear");
    drive(12'h000, 0, 0, 2'b01, 0, 1, 0, 1, 0, "R8 S menv set");
    drive(12'h000, 0, 0, 2'b11, 0, 0, 0, 1, 0, "R8 M never blocked");
    drive(12'h000, 0, 0, 2'b10, 0, 1, 0, 1, 0, "R8 reserved as U");
    // R9 legacy access not blocked
    drive(12'h000, 0, 0, 2'b00, 0, 0, 0, 0, 0, "R9 legacy U enables clear");
    drive(12'hBC0, 0, 0, 2'b01, 1, 0, 0, 0, 0, "R9 no request");
    // R10 writes leave registers unchanged
    drive(12'hBC0, 0, 1, 2'b11, 1, 1, 1, 0, 32'hFFFF_FFFF, "R10 mccsr write ones");
    drive(12'h8C0, 1, 1, 2'b00, 1, 1, 1, 0, 32'h0, "R10 uccsr write zeros");
    drive(12'hBC0, 1, 0, 2'b11, 1, 1, 1, 0, 0, "R10 mccsr readback");
    drive(12'h8C0, 1, 0, 2'b11, 1, 1, 1, 0, 0, "R10 uccsr readback");
    // R11 read data only on allowed control-register reads
    drive(12'h300, 1, 0, 2'b11, 1, 1, 1, 0, 0, "R11 other csr rdata");
    drive(12'hBC0, 1, 0, 2'b00, 1, 1, 1, 0, 0, "R11 refused read rdata");
    // R12 refusal plus capability trap combined
    drive(12'h9C0, 1, 0, 2'b00, 1, 1, 1, 1, 0, "R12 refused and enabled cap");
    drive(12'h001, 1, 0, 2'b00, 0, 0, 0, 1, 0, "R12 allowed but cap disabled");
    drive(12'h000, 0, 0, 2'b11, 0, 0, 0, 0, 0, "R9 idle end");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule